// File: doc/BRIEF.md
# Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division, signed or unsigned, and places its results in a dedicated pair of result registers, HI and LO. A product spans both registers: the upper half goes to HI and the lower half to LO. A division leaves the quotient in LO and the remainder in HI. Two move operations load HI or LO directly from an operand. The current contents of both registers are always visible on two read ports.

An operation is launched by a one-cycle start strobe carrying an operation code and two operands. Multiplication completes after a short fixed latency. Division runs as a restoring shift-and-subtract loop on operand magnitudes, one quotient bit per cycle, and corrects the signs at the end. While a multiply or divide is in flight the busy flag is high. The surrounding pipeline must not read HI or LO, and must not issue new work, until busy drops. A start seen while busy is discarded. Division by zero and the one overflowing signed quotient both give fixed, defined results rather than a trap.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `hi` and `lo` read 0 and `busy` is low.
- R2: Operation code 0 (signed multiply) writes the full 64-bit two's-complement product: bits 63:32 go to `hi` and bits 31:0 go to `lo`. The result is visible, with `busy` low, MUL_LAT clock edges after the edge that accepted the start.
- R3: Operation code 1 (unsigned multiply) writes the full 64-bit unsigned product, split across `hi` and `lo` as in R2, with the same timing.
- R4: Operation code 2 (signed divide) with a nonzero divisor writes the quotient, truncated toward zero, to `lo`. It writes the remainder, which carries the dividend's sign, to `hi`. The result is visible, with `busy` low, W+1 edges after the accepting edge.
- R5: Operation code 3 (unsigned divide) with a nonzero divisor writes the unsigned quotient to `lo` and the remainder to `hi`, with the timing of R4.
- R6: A signed divide by zero sets `lo` to 1 when the dividend is negative and to 0xFFFFFFFF otherwise. It sets `hi` to the dividend.
- R7: An unsigned divide by zero sets `lo` to 0xFFFFFFFF and `hi` to the dividend.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF sets `lo` to 0x80000000 and `hi` to 0.
- R9: Operation code 4 writes `opa` into `hi`, and operation code 5 writes `opa` into `lo`. The write happens at the accepting edge. The other register is unchanged and `busy` stays low.
- R10: `busy` is high from the edge after an accepted multiply or divide start until the result is written. `hi` and `lo` do not change at any other edge while busy.
- R11: A start while `busy` is high is ignored. The running operation finishes with its own result at its own time, and no further result follows.
- R12: Operation codes 6 and 7 are ignored: `hi`, `lo` and `busy` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that launches an operation |
| op | input | 3 | Operation code (see R2 to R12) |
| opa | input | 32 | First operand: multiplicand, dividend, or move source |
| opb | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | Multiply or divide in progress |
| hi | output | 32 | HI register contents |
| lo | output | 32 | LO register contents |

## Verification
The completion write of a divide and a fresh start request can fall on the same clock edge. At that edge `busy` is still high, so the request must lose. The bench provokes this by raising a move-to-HI start exactly in the cycle before the divide's completion edge. It then checks that `hi` holds the divide's remainder both at completion and one cycle later, and that the move left no trace. The same scoreboard also checks an ignored multiply start in the middle of a divide, comparing each popped result against its expected value and completion cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    MD_MULS  = 3'd0,
    MD_MULU  = 3'd1,
    MD_DIVS  = 3'd2,
    MD_DIVU  = 3'd3,
    MD_SETHI = 3'd4,
    MD_SETLO = 3'd5
  } md_op_e;
endpackage

// File: rtl/md_mul.sv
module md_mul #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(LAT + 1);

  logic           act_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] ax_q, bx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      ax_q  <= '0;
      bx_q  <= '0;
    end else if (go) begin
      act_q <= 1'b1;
      cnt_q <= CW'(LAT - 1);
      ax_q  <= {{W{sgn & a[W-1]}}, a};
      bx_q  <= {{W{sgn & b[W-1]}}, b};
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // Low 2W bits of the product of the extended operands are exact for both signednesses.
  assign prod = ax_q * bx_q;
  assign busy = act_q;
  assign done = act_q && (cnt_q == '0);

  // R11: the top never launches the multiplier while it is running
  a_r11_mul_go_idle: assert property (@(posedge clk) disable iff (rst) go |-> !act_q);
endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rmdr
);
  localparam int CW = $clog2(W + 1);

  logic          act_q, negq_q, negr_q, zero_q, sgn_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;

  logic          a_neg, b_neg;
  logic [W-1:0]  mag_a, mag_b;
  logic [W:0]    shifted;
  logic          ge;
  logic [W-1:0]  diff;

  assign a_neg   = sgn & a[W-1];
  assign b_neg   = sgn & b[W-1];
  assign mag_a   = a_neg ? (~a + 1'b1) : a;
  assign mag_b   = b_neg ? (~b + 1'b1) : b;
  assign shifted = {rem_q, quo_q[W-1]};
  assign ge      = shifted >= {1'b0, dvs_q};
  assign diff    = shifted[W-1:0] - dvs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (go) begin
      act_q  <= 1'b1;
      cnt_q  <= CW'(W);
      rem_q  <= '0;
      quo_q  <= mag_a;
      dvs_q  <= mag_b;
      dvd_q  <= a;
      negq_q <= a_neg ^ b_neg;
      negr_q <= a_neg;
      zero_q <= (b == '0);
      sgn_q  <= sgn;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_q <= 1'b0;
      end else begin
        // One restoring step: shift in the next dividend bit, subtract if it fits.
        rem_q <= ge ? diff : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (zero_q) begin
      quot = (sgn_q && dvd_q[W-1]) ? W'(1) : '1;
      rmdr = dvd_q;
    end else begin
      quot = negq_q ? (~quo_q + 1'b1) : quo_q;
      rmdr = negr_q ? (~rem_q + 1'b1) : rem_q;
    end
  end

  assign busy = act_q;
  assign done = act_q && (cnt_q == '0);

  // R4: magnitudes obey quotient*divisor + remainder = dividend at completion
  a_r4_div_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !zero_q) |->
      ({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, rem_q}) ==
      {{W{1'b0}}, (negr_q ? (~dvd_q + 1'b1) : dvd_q)});
  // R5: remainder magnitude smaller than divisor magnitude
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (done && !zero_q) |-> (rem_q < dvs_q));
  // R11: the top never launches the divider while it is running
  a_r11_div_go_idle: assert property (@(posedge clk) disable iff (rst) go |-> !act_q);
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic           accept, mul_go, div_go;
  logic           mul_busy, mul_done, div_busy, div_done;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quot, rmdr;
  logic [W-1:0]   hi_q, lo_q;

  assign accept = start && !busy;
  assign mul_go = accept && (op == MD_MULS || op == MD_MULU);
  assign div_go = accept && (op == MD_DIVS || op == MD_DIVU);
  assign busy   = mul_busy | div_busy;

  md_mul #(.W(W), .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .sgn(op == MD_MULS),
    .a(opa), .b(opb), .busy(mul_busy), .done(mul_done), .prod(prod)
  );

  md_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .sgn(op == MD_DIVS),
    .a(opa), .b(opb), .busy(div_busy), .done(div_done),
    .quot(quot), .rmdr(rmdr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (mul_done) begin
      hi_q <= prod[2*W-1:W];
      lo_q <= prod[W-1:0];
    end else if (div_done) begin
      hi_q <= rmdr;
      lo_q <= quot;
    end else if (accept && op == MD_SETHI) begin
      hi_q <= opa;
    end else if (accept && op == MD_SETLO) begin
      lo_q <= opa;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R9: move-to-HI lands at the accepting edge and leaves LO and busy alone
  a_r9_sethi: assert property (@(posedge clk) disable iff (rst)
    (accept && op == MD_SETHI) |=> (hi == $past(opa) && $stable(lo) && !busy));
  // R10: while busy, HI/LO move only at the completion edge
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !mul_done && !div_done) |=> ($stable(hi) && $stable(lo)));
  // R10: both engines are never active together
  a_r10_one_engine: assert property (@(posedge clk) disable iff (rst)
    !(mul_busy && div_busy));
  // R12: unused codes change nothing
  a_r12_badop: assert property (@(posedge clk) disable iff (rst)
    (accept && op[2:1] == 2'b11) |=> ($stable(hi) && $stable(lo) && !busy));
endmodule

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
  localparam int W       = 32;
  localparam int MUL_LAT = 2;
  localparam int DIV_LAT = W + 1;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy;
  logic [31:0] hi, lo;

  int   checks = 0, errors = 0, cyc = 0;
  bit   prev_busy = 1'b0;
  exp_t sb[$];

  muldiv_hilo #(.W(W), .MUL_LAT(MUL_LAT)) i_muldiv_hilo (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .hi(hi), .lo(lo)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb_, q, r;
    logic [63:0] p;
    sa  = longint'($signed(a));
    sb_ = longint'($signed(b));
    case (o)
      3'd0: p = 64'(sa * sb_);
      3'd1: p = {32'b0, a} * {32'b0, b};
      3'd2: begin
        if (b == 0) p = {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        else begin
          q = sa / sb_;
          r = sa % sb_;
          p = {r[31:0], q[31:0]};
        end
      end
      default: begin
        if (b == 0) p = {a, 32'hFFFF_FFFF};
        else p = {a % b, a / b};
      end
    endcase
    return p;
  endfunction

  // Driver: launches an operation and pushes its expected result
  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [63:0] e;
    exp_t it;
    while (busy) @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    e = model(o, a, b);
    it.hi = e[63:32]; it.lo = e[31:0]; it.tag = tag;
    it.due = cyc + ((o <= 3'd1) ? MUL_LAT : DIV_LAT);
    sb.push_back(it);
  endtask

  // Monitor: compares each completed result with the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_busy && !busy) begin
        if (sb.size() == 0) chk(1'b0, "R11 unexpected result", {hi, lo}, 64'd0);
        else begin
          exp_t it;
          it = sb.pop_front();
          chk(hi == it.hi && lo == it.lo, it.tag, {hi, lo}, {it.hi, it.lo});
          chk(cyc == it.due, {it.tag, " timing"}, 64'(cyc), 64'(it.due));
        end
      end
      prev_busy = busy;
    end
  end

  task automatic drain();
    while (busy || sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(hi == 0 && lo == 0, "R1 reset hi/lo", {hi, lo}, 64'd0);
    chk(busy == 1'b0, "R1 reset busy", 64'(busy), 64'd0);

    // R9 moves
    start = 1'b1; op = 3'd4; opa = 32'h1234_5678;
    @(negedge clk); start = 1'b0;
    chk(hi == 32'h1234_5678 && lo == 0 && !busy, "R9 move to hi", {hi, lo}, {32'h1234_5678, 32'd0});
    start = 1'b1; op = 3'd5; opa = 32'hCAFE_0001;
    @(negedge clk); start = 1'b0;
    chk(hi == 32'h1234_5678 && lo == 32'hCAFE_0001 && !busy, "R9 move to lo", {hi, lo}, {32'h1234_5678, 32'hCAFE_0001});

    // R12 unused codes
    start = 1'b1; op = 3'd6; opa = 32'hFFFF_0000;
    @(negedge clk); op = 3'd7;
    @(negedge clk); start = 1'b0;
    chk(hi == 32'h1234_5678 && lo == 32'hCAFE_0001 && !busy, "R12 unused codes", {hi, lo}, {32'h1234_5678, 32'hCAFE_0001});

    issue(3'd0, 32'd7, 32'hFFFF_FFFD, "R2 signed mul 7*-3");
    chk(busy == 1'b1, "R10 busy during mul", 64'(busy), 64'd1);
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R2 signed mul min*min");
    issue(3'd0, 32'h0001_2345, 32'h0006_789A, "R2 signed mul positive");
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 unsigned mul max*max");
    issue(3'd1, 32'h8000_0001, 32'd2, "R3 unsigned mul carry");
    issue(3'd2, 32'hFFFF_FFF9, 32'd2, "R4 signed div -7/2");
    chk(busy == 1'b1, "R10 busy during div", 64'(busy), 64'd1);
    issue(3'd2, 32'd7, 32'hFFFF_FFFE, "R4 signed div 7/-2");
    issue(3'd2, 32'd100, 32'd7, "R4 signed div 100/7");
    issue(3'd3, 32'hFFFF_FFFF, 32'd3, "R5 unsigned div max/3");
    issue(3'd3, 32'h8000_0000, 32'h0000_0007, "R5 unsigned div");
    issue(3'd2, 32'hFFFF_FFFB, 32'd0, "R6 signed div -5/0");
    issue(3'd2, 32'd5, 32'd0, "R6 signed div 5/0");
    issue(3'd2, 32'd0, 32'd0, "R6 signed div 0/0");
    issue(3'd3, 32'h8000_0000, 32'd0, "R7 unsigned div by zero");
    issue(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R8 signed overflow");
    drain();

    // R11: multiply start in the middle of a divide is dropped
    issue(3'd3, 32'd1000, 32'd33, "R11 divide survives mid start");
    repeat (5) @(negedge clk);
    start = 1'b1; op = 3'd0; opa = 32'd9; opb = 32'd9;
    @(negedge clk); start = 1'b0;
    drain();
    chk(hi == 32'd10 && lo == 32'd30, "R11 final hi/lo", {hi, lo}, {32'd10, 32'd30});

    // R11/R10: move-to-HI on the divide's completion edge is dropped
    issue(3'd2, 32'hFFFF_FF00, 32'd7, "R11 coincident completion");
    while (cyc != sb[0].due - 1) @(negedge clk);
    start = 1'b1; op = 3'd4; opa = 32'hDEAD_BEEF;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(hi == 32'hFFFF_FFFC, "R11 move dropped at completion", {32'd0, hi}, {32'd0, 32'hFFFF_FFFC});
    chk(!busy && sb.size() == 0, "R11 no trailing result", 64'(sb.size()), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule